// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block predicts whether a conditional branch is taken by running two direction predictors side by side and letting a per-address selector decide which one to trust. The first predictor is indexed by a shift register of the most recent branch outcomes across the whole program. The second predictor works in two steps. A table indexed by branch address holds each branch's own recent outcomes. That per-branch pattern then indexes a table of wider saturating counters.

A lookup presents a PC and gets back, in the same cycle and from combinational logic, the final direction. It also gets both component directions and the selector's choice. The caller keeps the component directions and hands them back with the resolved outcome. On that update the block trains both component counters toward the outcome. It trains the selector only when the two components disagreed. It then shifts the outcome into the global history and into that branch's local history. A lookup in the same cycle as an update sees the state from before the update.

Top module: `tourney_bp`

## Requirements
- R1: After reset the global counters hold 1, the local pattern counters hold 3, the selector counters hold 1 (weakly local) and both histories are zero. Every lookup then returns 0 for the global direction, the local direction, the selector choice and the final direction.
- R2: The global direction is taken when the 2-bit counter indexed by the 12-bit global history is 2 or more.
- R3: The local direction is taken when the 3-bit counter indexed by the branch's 10-bit local history is 4 or more. The local history entry is selected by PC bits [11:2].
- R4: The selector counter, indexed by PC bits [13:2], chooses global when its MSB is 1 and local when its MSB is 0. The final direction is the chosen component's direction.
- R5: On an update whose saved component directions differ, the selector counter steps by one toward the component that matched the outcome: up for global, down for local. When the saved directions agree, the selector counter is unchanged.
- R6: Every update moves both the indexed global counter and the indexed local counter one step toward the outcome, whichever component was chosen. The counters saturate at 0 and at their maximum (3 for global, 7 for local).
- R7: Every update shifts the outcome into bit 0 of the global history and into bit 0 of the updated branch's local history entry.
- R8: A lookup in the same cycle as an update returns values from the state before that update. The effect of the update is visible from the next cycle.
- R9: When the update valid input is low, the other update inputs are ignored and no predictor state changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lk_pc | input | PC_W | Lookup PC |
| lk_taken | output | 1 | Final predicted direction |
| lk_glob_pred | output | 1 | Global-history component direction |
| lk_loc_pred | output | 1 | Local-history component direction |
| lk_pick_global | output | 1 | 1 when the selector chose the global component |
| up_valid | input | 1 | Update strobe |
| up_pc | input | PC_W | PC of the resolved branch |
| up_taken | input | 1 | Resolved outcome |
| up_glob_pred | input | 1 | Saved global component direction |
| up_loc_pred | input | 1 | Saved local component direction |

## Verification
A lookup and an update can fall in the same cycle, possibly for the same PC. In that case the lookup must read the tables and histories as they were before that clock edge. The bench provokes this by holding the lookup PC on the branch being updated while the update strobe is high. It samples just before the edge and compares against its own model's pre-update state. It samples again one cycle later and compares against the post-update state. The idle case, with update inputs toggling and the strobe low, is judged the same way: the lookup results must not move.

// File: rtl/tourney_bp.sv
module tourney_bp #(
  parameter int PC_W     = 32,
  parameter int ALIGN    = 2,
  parameter int GH_W     = 12,
  parameter int LH_W     = 10,
  parameter int LHT_BITS = 10,
  parameter int SEL_BITS = 12,
  parameter int GCTR_W   = 2,
  parameter int LCTR_W   = 3,
  parameter int SCTR_W   = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PC_W-1:0] lk_pc,
  output logic            lk_taken,
  output logic            lk_glob_pred,
  output logic            lk_loc_pred,
  output logic            lk_pick_global,
  input  logic            up_valid,
  input  logic [PC_W-1:0] up_pc,
  input  logic            up_taken,
  input  logic            up_glob_pred,
  input  logic            up_loc_pred
);
  localparam int GP_N  = 1 << GH_W;
  localparam int LP_N  = 1 << LH_W;
  localparam int LHT_N = 1 << LHT_BITS;
  localparam int SEL_N = 1 << SEL_BITS;
  localparam logic [GCTR_W-1:0] G_INIT = GCTR_W'((1 << (GCTR_W-1)) - 1);
  localparam logic [LCTR_W-1:0] L_INIT = LCTR_W'((1 << (LCTR_W-1)) - 1);
  localparam logic [SCTR_W-1:0] S_INIT = SCTR_W'((1 << (SCTR_W-1)) - 1);
  localparam logic [GCTR_W-1:0] G_MAX  = '1;
  localparam logic [LCTR_W-1:0] L_MAX  = '1;
  localparam logic [SCTR_W-1:0] S_MAX  = '1;

  logic [GCTR_W-1:0] gpt [GP_N];
  logic [LCTR_W-1:0] lpt [LP_N];
  logic [LH_W-1:0]   lht [LHT_N];
  logic [SCTR_W-1:0] sel [SEL_N];
  logic [GH_W-1:0]   ghist;

  logic [SEL_BITS-1:0] lk_si, up_si;
  logic [LHT_BITS-1:0] lk_hi, up_hi;
  logic [LH_W-1:0]     lk_lh, up_lh;
  logic [GCTR_W-1:0]   g_cur;
  logic [LCTR_W-1:0]   l_cur;
  logic [SCTR_W-1:0]   s_cur;

  assign lk_si = lk_pc[ALIGN +: SEL_BITS];
  assign lk_hi = lk_pc[ALIGN +: LHT_BITS];
  assign up_si = up_pc[ALIGN +: SEL_BITS];
  assign up_hi = up_pc[ALIGN +: LHT_BITS];
  assign lk_lh = lht[lk_hi];
  assign up_lh = lht[up_hi];

  assign lk_glob_pred   = gpt[ghist][GCTR_W-1];
  assign lk_loc_pred    = lpt[lk_lh][LCTR_W-1];
  assign lk_pick_global = sel[lk_si][SCTR_W-1];
  assign lk_taken       = lk_pick_global ? lk_glob_pred : lk_loc_pred;

  assign g_cur = gpt[ghist];
  assign l_cur = lpt[up_lh];
  assign s_cur = sel[up_si];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < GP_N; i++)  gpt[i] <= G_INIT;
      for (int i = 0; i < LP_N; i++)  lpt[i] <= L_INIT;
      for (int i = 0; i < LHT_N; i++) lht[i] <= '0;
      for (int i = 0; i < SEL_N; i++) sel[i] <= S_INIT;
      ghist <= '0;
    end else if (up_valid) begin
      if (up_taken && g_cur != G_MAX)      gpt[ghist] <= g_cur + 1'b1;
      else if (!up_taken && g_cur != '0)   gpt[ghist] <= g_cur - 1'b1;

      if (up_taken && l_cur != L_MAX)      lpt[up_lh] <= l_cur + 1'b1;
      else if (!up_taken && l_cur != '0)   lpt[up_lh] <= l_cur - 1'b1;

      if (up_glob_pred != up_loc_pred) begin
        if (up_glob_pred == up_taken && s_cur != S_MAX) sel[up_si] <= s_cur + 1'b1;
        else if (up_loc_pred == up_taken && s_cur != '0) sel[up_si] <= s_cur - 1'b1;
      end

      ghist      <= {ghist[GH_W-2:0], up_taken};
      lht[up_hi] <= {up_lh[LH_W-2:0], up_taken};
    end
  end
endmodule

// File: rtl/tourney_bp_chk.sv
module tourney_bp_chk #(
  parameter int PC_W = 32,
  parameter int GH_W = 12
) (
  input logic            clk,
  input logic            rst,
  input logic [PC_W-1:0] lk_pc,
  input logic            lk_taken,
  input logic            lk_glob_pred,
  input logic            lk_loc_pred,
  input logic            lk_pick_global,
  input logic            up_valid,
  input logic [PC_W-1:0] up_pc,
  input logic            up_taken,
  input logic            up_glob_pred,
  input logic            up_loc_pred,
  input logic [GH_W-1:0] ghist
);
  a_r4_agree_passes: assert property (@(posedge clk) disable iff (rst)
    (lk_glob_pred == lk_loc_pred) |-> (lk_taken == lk_glob_pred));

  a_r7_ghist_in: assert property (@(posedge clk) disable iff (rst)
    up_valid |=> ghist[0] == $past(up_taken));

  a_r7_ghist_shift: assert property (@(posedge clk) disable iff (rst)
    up_valid |=> ghist[GH_W-1:1] == $past(ghist[GH_W-2:0]));

  a_r9_ghist_hold: assert property (@(posedge clk) disable iff (rst)
    !up_valid |=> $stable(ghist));

  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !up_valid |=> ($stable(lk_pc) -> ($stable(lk_taken) && $stable(lk_pick_global))));

  a_r5_agree_keeps_sel: assert property (@(posedge clk) disable iff (rst)
    (up_valid && up_glob_pred == up_loc_pred && lk_pc == up_pc)
      |=> ($stable(lk_pc) -> $stable(lk_pick_global)));
endmodule

bind tourney_bp tourney_bp_chk #(.PC_W(PC_W), .GH_W(GH_W)) u_chk (
  .clk(clk), .rst(rst), .lk_pc(lk_pc), .lk_taken(lk_taken),
  .lk_glob_pred(lk_glob_pred), .lk_loc_pred(lk_loc_pred),
  .lk_pick_global(lk_pick_global), .up_valid(up_valid), .up_pc(up_pc),
  .up_taken(up_taken), .up_glob_pred(up_glob_pred), .up_loc_pred(up_loc_pred),
  .ghist(ghist));

// File: tb/tourney_bp_tb.sv
module tourney_bp_tb;
  logic        clk = 0;
  logic        rst = 1;
  logic [31:0] lk_pc = '0;
  logic        lk_taken, lk_glob_pred, lk_loc_pred, lk_pick_global;
  logic        up_valid = 0;
  logic [31:0] up_pc = '0;
  logic        up_taken = 0, up_glob_pred = 0, up_loc_pred = 0;

  int checks = 0;
  int errors = 0;

  int m_gp [4096];
  int m_lp [1024];
  int m_lh [1024];
  int m_sel[4096];
  int m_gh;

  always #5 clk = ~clk;

  tourney_bp u_dut (
    .clk(clk), .rst(rst), .lk_pc(lk_pc), .lk_taken(lk_taken),
    .lk_glob_pred(lk_glob_pred), .lk_loc_pred(lk_loc_pred),
    .lk_pick_global(lk_pick_global), .up_valid(up_valid), .up_pc(up_pc),
    .up_taken(up_taken), .up_glob_pred(up_glob_pred), .up_loc_pred(up_loc_pred));

  function automatic int si(input logic [31:0] pc); return int'(pc[13:2]); endfunction
  function automatic int hi(input logic [31:0] pc); return int'(pc[11:2]); endfunction
  function automatic bit e_glob();              return m_gp[m_gh] >= 2; endfunction
  function automatic bit e_loc(input logic [31:0] pc); return m_lp[m_lh[hi(pc)]] >= 4; endfunction
  function automatic bit e_pick(input logic [31:0] pc); return m_sel[si(pc)] >= 2; endfunction

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 4096; i++) begin m_gp[i] = 1; m_sel[i] = 1; end
    for (int i = 0; i < 1024; i++) begin m_lp[i] = 3; m_lh[i] = 0; end
    m_gh = 0;
  endtask

  task automatic model_update(input logic [31:0] pc, input bit t, input bit gp, input bit lp);
    int li;
    li = m_lh[hi(pc)];
    if (t) begin
      if (m_gp[m_gh] < 3) m_gp[m_gh]++;
      if (m_lp[li] < 7) m_lp[li]++;
    end else begin
      if (m_gp[m_gh] > 0) m_gp[m_gh]--;
      if (m_lp[li] > 0) m_lp[li]--;
    end
    if (gp != lp) begin
      if (gp == t && m_sel[si(pc)] < 3) m_sel[si(pc)]++;
      else if (lp == t && m_sel[si(pc)] > 0) m_sel[si(pc)]--;
    end
    m_gh = ((m_gh << 1) | int'(t)) & 12'hfff;
    m_lh[hi(pc)] = ((li << 1) | int'(t)) & 10'h3ff;
  endtask

  // Called at a negedge; samples 1 ns later.
  task automatic look(input logic [31:0] pc, input string req);
    lk_pc = pc;
    #1;
    chk("R2", {req, " glob"}, lk_glob_pred, e_glob());
    chk("R3", {req, " loc"}, lk_loc_pred, e_loc(pc));
    chk("R4", {req, " pick"}, lk_pick_global, e_pick(pc));
    chk("R4", {req, " final"}, lk_taken, e_pick(pc) ? e_glob() : e_loc(pc));
  endtask

  task automatic upd(input logic [31:0] pc, input bit t, input bit gp, input bit lp);
    @(negedge clk);
    up_valid = 1; up_pc = pc; up_taken = t; up_glob_pred = gp; up_loc_pred = lp;
    @(posedge clk);
    model_update(pc, t, gp, lp);
    @(negedge clk);
    up_valid = 0;
  endtask

  // Look up, then resolve with the returned component directions.
  task automatic run(input logic [31:0] pc, input bit t, input string req);
    bit g, l;
    @(negedge clk);
    look(pc, req);
    g = lk_glob_pred; l = lk_loc_pred;
    upd(pc, t, g, l);
  endtask

  task automatic t_reset();
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      lk_pc = 32'h1000 * k + 32'h40;
      #1;
      chk("R1", "reset glob", lk_glob_pred, 1'b0);
      chk("R1", "reset loc", lk_loc_pred, 1'b0);
      chk("R1", "reset pick", lk_pick_global, 1'b0);
      chk("R1", "reset final", lk_taken, 1'b0);
    end
  endtask

  task automatic t_global();
    for (int k = 0; k < 8; k++) run(32'h100, 1'b1, "R2 R7 bias");
    for (int k = 0; k < 8; k++) run(32'h100 + 32'(k * 4), k[0], "R2 R7 mix");
  endtask

  task automatic t_local();
    for (int k = 0; k < 45; k++) run(32'h200, (k % 3) != 2, "R3 R7 pattern");
    @(negedge clk);
    look(32'h200, "R3 learned");
  endtask

  task automatic t_chooser();
    @(negedge clk); look(32'h300, "R5 start");
    chk("R5", "start pick", lk_pick_global, 1'b0);
    upd(32'h300, 1'b1, 1'b1, 1'b0);
    @(negedge clk); look(32'h300, "R5 toward global");
    chk("R5", "pick after global right", lk_pick_global, 1'b1);
    upd(32'h300, 1'b0, 1'b1, 1'b1);
    @(negedge clk); look(32'h300, "R5 agree");
    chk("R5", "pick after agree", lk_pick_global, 1'b1);
    upd(32'h300, 1'b1, 1'b1, 1'b0);
    upd(32'h300, 1'b1, 1'b1, 1'b0);
    @(negedge clk); look(32'h300, "R5 saturate high");
    upd(32'h300, 1'b1, 1'b0, 1'b1);
    @(negedge clk); look(32'h300, "R5 one down");
    chk("R5", "pick after one local win", lk_pick_global, 1'b1);
    upd(32'h300, 1'b1, 1'b0, 1'b1);
    @(negedge clk); look(32'h300, "R5 two down");
    chk("R5", "pick after two local wins", lk_pick_global, 1'b0);
  endtask

  task automatic t_saturate();
    for (int k = 0; k < 14; k++) run(32'h400, 1'b1, "R6 climb");
    run(32'h400, 1'b0, "R6 top");
    for (int k = 0; k < 3; k++) run(32'h400, 1'b1, "R6 after dip");
    for (int k = 0; k < 16; k++) run(32'h404, 1'b0, "R6 floor");
  endtask

  task automatic t_idle();
    @(negedge clk); look(32'h200, "R9 before");
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      up_pc = 32'h200; up_taken = k[0]; up_glob_pred = k[1]; up_loc_pred = ~k[0];
      look(32'h200, "R9 idle");
    end
  endtask

  task automatic t_same_cycle();
    for (int k = 0; k < 4; k++) begin
      bit t;
      t = (k != 2);
      @(negedge clk);
      lk_pc = 32'h500;
      #1;
      up_valid = 1; up_pc = 32'h500; up_taken = t;
      up_glob_pred = lk_glob_pred; up_loc_pred = ~lk_glob_pred;
      #2;
      look(32'h500, "R8 before edge");
      @(posedge clk);
      model_update(32'h500, t, up_glob_pred, up_loc_pred);
      @(negedge clk);
      up_valid = 0;
      look(32'h500, "R8 after edge");
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    t_reset();
    t_global();
    t_local();
    t_chooser();
    t_saturate();
    t_idle();
    t_same_cycle();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule